// File: doc/BRIEF.md
# Long-Press Manual Reset Supervisor

This block produces the active-low system reset for a chip. It combines two sources. The first is a set of supply-good flags from external voltage comparators. The second is one or two active-low front-panel pushbuttons. A supply that is not good holds the reset asserted. Once every supply is good, the reset stays asserted for a fixed timeout and then releases.

A pushbutton only causes a reset after it has been held for a long setup time, on the order of seconds. When that happens, the block fires one reset pulse of the normal timeout length. A shorter press does nothing to the reset. It only shows up on a separate press flag, which firmware can use as an interrupt. In dual-button mode both buttons must be held at the same moment.

Every duration is counted in ticks of a slow enable input, so second-scale periods fit in narrow counters. All asynchronous inputs pass through two-flop synchronizers.

Top module: `longpress_reset_ctrl`

## Requirements
- R1: During and directly after the block's own reset (`rst_n` low), `rst_out_n` is 0 and `press_irq` is 0.
- R2: If any bit of `supply_ok` is 0, `rst_out_n` is driven 0 no later than three clock cycles after that bit reaches the input, and it stays 0 for as long as the bit stays 0.
- R3: Once every `supply_ok` bit is 1, `rst_out_n` stays 0 for `RST_TICKS` ticks and then goes to 1. It only goes to 1 in the cycle after a tick.
- R4: A press held for `SETUP_TICKS` ticks drives `rst_out_n` to 0 for `RST_TICKS` ticks and then back to 1, even while the press continues.
- R5: A press shorter than the setup period never drives `rst_out_n` low.
- R6: With `DUAL_BTN=1`, a press means `btn_a_n` and `btn_b_n` are both 0. Holding only one of them never fires. Releasing either one for longer than the release debounce restarts the setup count.
- R7: One valid hold gives exactly one reset pulse. A new pulse requires the press to be released (past the debounce) and a new full setup period.
- R8: A release shorter than `DEB_TICKS` ticks is ignored. It neither restarts the setup count nor re-arms a hold that has already fired.
- R9: `press_irq` goes to 1 three clock cycles after a press reaches the inputs. It goes back to 0 only after the press has been absent for `DEB_TICKS` ticks.
- R10: A supply failure during a manual pulse keeps `rst_out_n` at 0 for as long as the failure lasts. The full `RST_TICKS` timeout then restarts once all supplies are good again.
- R11: With `DUAL_BTN=0`, only `btn_a_n` is a press. `btn_b_n` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block's own asynchronous active-low reset |
| tick | input | 1 | Slow timing enable; every counter advances only when this is 1 |
| supply_ok | input | N_SUPPLY | Supply-good flags from external comparators, 1 = good (asynchronous) |
| btn_a_n | input | 1 | First pushbutton, active low (asynchronous) |
| btn_b_n | input | 1 | Second pushbutton, active low; used only in dual mode |
| rst_out_n | output | 1 | Registered active-low system reset |
| press_irq | output | 1 | Debounced press flag for use as an interrupt |

## Verification
The hardest situations to reach are the ones where timers overlap. One is a supply failure that arrives while a manual pulse is already running. Another is a short release that lands in the middle of a setup count, or after a pulse has already fired. The stimulus reaches these by timing its input changes against the known setup and timeout lengths. It drops a supply partway into a manual pulse. It opens one button for less than the debounce both during a count and after a firing. It opens a button for longer than the debounce so that a count has to restart. A behavioural model with the same timings is compared against both outputs on every cycle, for one dual-mode instance and one single-mode instance.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction
endpackage

// File: rtl/lrc_sync.sv
module lrc_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] out_q, out_d;

    always_comb begin
        meta_d = din;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            out_q  <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/lrc_press_filter.sv
module lrc_press_filter #(
    parameter int unsigned DEB_TICKS = 210
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pressed_raw,
    output logic held
);
    localparam int unsigned DW = lrc_pkg::cnt_width(DEB_TICKS);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_TICKS - 1);

    logic          held_q, held_d;
    logic [DW-1:0] gap_q, gap_d;

    always_comb begin
        held_d = held_q;
        gap_d  = gap_q;
        if (pressed_raw) begin
            held_d = 1'b1;
            gap_d  = '0;
        end else if (held_q && tick) begin
            if (gap_q == DEB_LAST) begin
                held_d = 1'b0;
                gap_d  = '0;
            end else begin
                gap_d = gap_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            held_q <= held_d;
            gap_q  <= gap_d;
        end
    end

    assign held = held_q;
endmodule

// File: rtl/longpress_reset_ctrl.sv
module longpress_reset_ctrl #(
    parameter int unsigned N_SUPPLY    = 2,
    parameter bit          DUAL_BTN    = 1'b1,
    parameter int unsigned SETUP_TICKS = 6720,
    parameter int unsigned RST_TICKS   = 210,
    parameter int unsigned DEB_TICKS   = 210
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [N_SUPPLY-1:0] supply_ok,
    input  logic                btn_a_n,
    input  logic                btn_b_n,
    output logic                rst_out_n,
    output logic                press_irq
);
    localparam int unsigned SW = lrc_pkg::cnt_width(SETUP_TICKS);
    localparam int unsigned RW = lrc_pkg::cnt_width(RST_TICKS);
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_TICKS - 1);
    localparam logic [RW-1:0] RST_LAST   = RW'(RST_TICKS - 1);
    localparam int unsigned SYW = N_SUPPLY + 2;

    typedef struct packed {
        logic          asrt;
        logic [RW-1:0] rcnt;
        logic [SW-1:0] scnt;
        logic          fired;
    } ctrl_t;

    ctrl_t q_q, q_d;

    logic [SYW-1:0]      sync_out;
    logic [N_SUPPLY-1:0] sup_s;
    logic [1:0]          btn_s;
    logic                all_ok_s;
    logic                pressed_raw;
    logic                held;
    logic                fire;
    logic                fired_q;

    lrc_sync #(
        .WIDTH  (SYW),
        .RST_VAL({2'b11, {N_SUPPLY{1'b0}}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({btn_b_n, btn_a_n, supply_ok}),
        .dout (sync_out)
    );

    assign sup_s    = sync_out[N_SUPPLY-1:0];
    assign btn_s    = sync_out[SYW-1:N_SUPPLY];
    assign all_ok_s = &sup_s;

    generate
        if (DUAL_BTN) begin : g_dual
            assign pressed_raw = ~btn_s[0] & ~btn_s[1];
        end else begin : g_single
            logic unused_btn_b;
            assign unused_btn_b = btn_s[1];
            assign pressed_raw  = ~btn_s[0];
        end
    endgenerate

    lrc_press_filter #(
        .DEB_TICKS(DEB_TICKS)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pressed_raw(pressed_raw),
        .held       (held)
    );

    assign fire = held && !q_q.fired && tick && (q_q.scnt == SETUP_LAST);

    always_comb begin
        q_d = q_q;
        // setup count for the long press
        if (!held) begin
            q_d.scnt  = '0;
            q_d.fired = 1'b0;
        end else if (!q_q.fired && tick) begin
            if (fire) begin
                q_d.scnt  = '0;
                q_d.fired = 1'b1;
            end else begin
                q_d.scnt = q_q.scnt + 1'b1;
            end
        end
        // reset output: supply hold wins over the manual pulse
        if (!all_ok_s) begin
            q_d.asrt = 1'b1;
            q_d.rcnt = '0;
        end else if (fire) begin
            q_d.asrt = 1'b1;
            q_d.rcnt = '0;
        end else if (q_q.asrt && tick) begin
            if (q_q.rcnt == RST_LAST) begin
                q_d.asrt = 1'b0;
                q_d.rcnt = '0;
            end else begin
                q_d.rcnt = q_q.rcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.asrt  <= 1'b1;
            q_q.rcnt  <= '0;
            q_q.scnt  <= '0;
            q_q.fired <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign fired_q   = q_q.fired;
    assign rst_out_n = ~q_q.asrt;
    assign press_irq = held;
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic all_ok_s,
    input logic pressed_raw,
    input logic fired_q,
    input logic rst_out_n,
    input logic press_irq
);
    // R2: a bad synchronized supply holds the reset on the next cycle
    a_r2_supply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(all_ok_s) |-> !rst_out_n);

    // R3: release happens only on a tick while supplies are good
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tick) && $past(all_ok_s)));

    // R4: a completed setup period always produces an asserted reset
    a_r4_fire_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired_q) |-> !rst_out_n);

    // R5: firing needs a debounced press that was already present
    a_r5_fire_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired_q) |-> $past(press_irq));

    // R7: no second manual pulse while the same hold stays armed-off
    a_r7_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && $past(fired_q)) |-> !($fell(rst_out_n) && $past(all_ok_s)));

    // R9: press flag rises only after a raw press was seen
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(press_irq) |-> $past(pressed_raw));
endmodule

bind longpress_reset_ctrl lrc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .all_ok_s   (all_ok_s),
    .pressed_raw(pressed_raw),
    .fired_q    (fired_q),
    .rst_out_n  (rst_out_n),
    .press_irq  (press_irq)
);

// File: tb/longpress_reset_ctrl_tb.sv
module lrc_ref_model #(
    parameter int N     = 2,
    parameter bit DUAL  = 1'b1,
    parameter int SETUP = 20,
    parameter int RST   = 6,
    parameter int DEB   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] sup,
    input  logic         a_n,
    input  logic         b_n,
    output logic         exp_rst_n,
    output logic         exp_irq
);
    logic [N-1:0] qs[$];
    logic         qa[$];
    logic         qb[$];
    int held, gap, scnt, fired, asrt, rcnt;

    initial begin
        held = 0; gap = 0; scnt = 0; fired = 0; asrt = 1; rcnt = 0;
        exp_rst_n = 1'b0; exp_irq = 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            qs.delete(); qa.delete(); qb.delete();
            repeat (2) begin qs.push_back('0); qa.push_back(1'b1); qb.push_back(1'b1); end
            held = 0; gap = 0; scnt = 0; fired = 0; asrt = 1; rcnt = 0;
        end else begin
            logic [N-1:0] s;
            logic a, b;
            int pressed, fire, old_held;
            s = qs[0]; a = qa[0]; b = qb[0];
            pressed  = DUAL ? (!a && !b) : !a;
            old_held = held;
            fire = (old_held && !fired && tick && scnt == SETUP - 1);
            if (pressed) begin held = 1; gap = 0; end
            else if (held && tick) begin
                if (gap == DEB - 1) begin held = 0; gap = 0; end else gap++;
            end
            if (!old_held) begin scnt = 0; fired = 0; end
            else if (!fired && tick) begin
                if (fire) begin scnt = 0; fired = 1; end else scnt++;
            end
            if (s != {N{1'b1}}) begin asrt = 1; rcnt = 0; end
            else if (fire) begin asrt = 1; rcnt = 0; end
            else if (asrt && tick) begin
                if (rcnt == RST - 1) begin asrt = 0; rcnt = 0; end else rcnt++;
            end
            void'(qs.pop_front()); void'(qa.pop_front()); void'(qb.pop_front());
            qs.push_back(sup); qa.push_back(a_n); qb.push_back(b_n);
        end
        exp_rst_n = !asrt;
        exp_irq   = (held != 0);
    end
endmodule

module longpress_reset_ctrl_tb;
    localparam int N = 2, SETUP = 20, RST = 6, DEB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [N-1:0] sup = '0;
    logic a_n = 1'b1, b_n = 1'b1;
    logic d_rst_n, d_irq, s_rst_n, s_irq;
    logic m_d_rst_n, m_d_irq, m_s_rst_n, m_s_irq;

    int checks = 0, failures = 0, cyc = 0, tdiv = 0;
    int fall_d = 0, fall_s = 0;
    logic prev_d = 1'b0, prev_s = 1'b0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    longpress_reset_ctrl #(.N_SUPPLY(N), .DUAL_BTN(1'b1), .SETUP_TICKS(SETUP),
        .RST_TICKS(RST), .DEB_TICKS(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(sup),
        .btn_a_n(a_n), .btn_b_n(b_n), .rst_out_n(d_rst_n), .press_irq(d_irq));

    longpress_reset_ctrl #(.N_SUPPLY(N), .DUAL_BTN(1'b0), .SETUP_TICKS(SETUP),
        .RST_TICKS(RST), .DEB_TICKS(DEB)) u_single (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(sup),
        .btn_a_n(a_n), .btn_b_n(b_n), .rst_out_n(s_rst_n), .press_irq(s_irq));

    lrc_ref_model #(.N(N), .DUAL(1'b1), .SETUP(SETUP), .RST(RST), .DEB(DEB)) m_d (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sup(sup), .a_n(a_n), .b_n(b_n),
        .exp_rst_n(m_d_rst_n), .exp_irq(m_d_irq));

    lrc_ref_model #(.N(N), .DUAL(1'b0), .SETUP(SETUP), .RST(RST), .DEB(DEB)) m_s (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sup(sup), .a_n(a_n), .b_n(b_n),
        .exp_rst_n(m_s_rst_n), .exp_irq(m_s_irq));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // tick every fourth clock, driven away from the active edge
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 3);
    end

    // per-cycle comparison against the behavioural model, plus edge counters
    always @(negedge clk) begin
        if (cyc > 1 && !done) begin
            chk(cur_req, "dual rst_out_n", d_rst_n, m_d_rst_n);
            chk(cur_req, "dual press_irq", d_irq, m_d_irq);
            chk(cur_req, "single rst_out_n", s_rst_n, m_s_rst_n);
            chk(cur_req, "single press_irq", s_irq, m_s_irq);
            if (prev_d && !d_rst_n) fall_d++;
            if (prev_s && !s_rst_n) fall_s++;
        end
        prev_d = d_rst_n;
        prev_s = s_rst_n;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f0, s0;
        // R1: reset state
        wclk(5);
        cur_req = "R1";
        chk("R1", "rst_out_n in reset", d_rst_n, 1'b0);
        chk("R1", "press_irq in reset", d_irq, 1'b0);
        sup = '1;
        rst_n = 1'b1;
        wclk(2);
        chk("R1", "rst_out_n after reset", d_rst_n, 1'b0);
        // R3: power-up timeout
        cur_req = "R3";
        wclk(10);
        chk("R3", "held during timeout", d_rst_n, 1'b0);
        wclk(30);
        chk("R3", "released after timeout", d_rst_n, 1'b1);
        // R2: one supply drops
        cur_req = "R2";
        sup[1] = 1'b0;
        wclk(3);
        chk("R2", "asserted 3 cycles after drop", d_rst_n, 1'b0);
        wclk(20);
        chk("R2", "still asserted while bad", d_rst_n, 1'b0);
        sup[1] = 1'b1;
        cur_req = "R3";
        wclk(10);
        chk("R3", "timeout after recovery", d_rst_n, 1'b0);
        wclk(30);
        chk("R3", "released after recovery", d_rst_n, 1'b1);
        // R5 + R9: short dual press
        cur_req = "R5";
        f0 = fall_d;
        a_n = 0; b_n = 0;
        wclk(3);
        chk("R9", "irq three cycles after press", d_irq, 1'b1);
        wclk(37);
        a_n = 1; b_n = 1;
        wclk(6);
        chk("R9", "irq held through debounce", d_irq, 1'b1);
        wclk(20);
        chk("R9", "irq low after debounce", d_irq, 1'b0);
        chk_int("R5", "no pulse from short press", fall_d - f0, 0);
        wclk(10);
        // R6: only A held (single instance fires)
        cur_req = "R6";
        f0 = fall_d; s0 = fall_s;
        a_n = 0;
        wclk(120);
        chk("R6", "dual irq with one button", d_irq, 1'b0);
        chk_int("R6", "dual no pulse with one button", fall_d - f0, 0);
        chk_int("R11", "single fires on A", fall_s - s0, 1);
        a_n = 1;
        wclk(40);
        // R11: only B held
        cur_req = "R11";
        s0 = fall_s;
        b_n = 0;
        wclk(120);
        chk("R11", "single irq ignores B", s_irq, 1'b0);
        chk_int("R11", "single no pulse on B", fall_s - s0, 0);
        b_n = 1;
        wclk(40);
        // R4 + R7 + R8: long hold, then a short release bounce
        cur_req = "R4";
        f0 = fall_d;
        a_n = 0; b_n = 0;
        wclk(95);
        chk("R4", "pulse active", d_rst_n, 1'b0);
        wclk(35);
        chk("R4", "pulse ended while held", d_rst_n, 1'b1);
        cur_req = "R8";
        b_n = 1;
        wclk(4);
        b_n = 0;
        wclk(120);
        chk_int("R7", "one pulse for one hold", fall_d - f0, 1);
        chk_int("R8", "bounce did not re-arm", fall_d - f0, 1);
        a_n = 1; b_n = 1;
        wclk(40);
        // R8: bounce mid-count does not restart
        f0 = fall_d;
        a_n = 0; b_n = 0;
        wclk(50);
        b_n = 1;
        wclk(4);
        b_n = 0;
        wclk(41);
        chk("R8", "count survived bounce", d_rst_n, 1'b0);
        wclk(40);
        a_n = 1; b_n = 1;
        wclk(40);
        chk_int("R8", "one pulse after bounce", fall_d - f0, 1);
        // R6: long release restarts count
        cur_req = "R6";
        f0 = fall_d;
        a_n = 0; b_n = 0;
        wclk(50);
        a_n = 1;
        wclk(30);
        a_n = 0;
        wclk(50);
        chk_int("R6", "restart after release", fall_d - f0, 0);
        a_n = 1; b_n = 1;
        wclk(40);
        // R10: supply fails during a manual pulse
        cur_req = "R10";
        a_n = 0; b_n = 0;
        wclk(95);
        chk("R10", "manual pulse active", d_rst_n, 1'b0);
        sup[0] = 1'b0;
        wclk(40);
        chk("R10", "held by supply", d_rst_n, 1'b0);
        sup[0] = 1'b1;
        wclk(10);
        chk("R10", "timeout restarted", d_rst_n, 1'b0);
        wclk(30);
        chk("R10", "released after restart", d_rst_n, 1'b1);
        a_n = 1; b_n = 1;
        wclk(40);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule